// File: doc/BRIEF.md
# Multiplexed LCD Row Scan Controller

This block walks a banked display memory one multiplexed row at a time and presents the dot values of all 40 columns for the row being driven. The memory holds four banks, each made of one byte per column; eight rows share a bank, and each row takes one bit of every column byte. The row counter moves forward on an external step enable and is forced back to row 0 by a synchronisation pulse, so that several cascaded drivers scan the same row at the same time.

A configuration word, captured on a write strobe, sets the scan length (8, 16, 24 or 32 rows), the bank shown at the top of the screen (rotating it scrolls the picture in steps of eight rows) and the display status: blank, all dots lit, normal or inverse. The memory read port is combinational and external: the block drives a bank index and receives the 40 column bytes of that bank.

Top module: `lcd_row_scan`

## Requirements
- R1: After reset the row index is 0, the column vector is all zeros, and the captured configuration is 32 rows, top bank 0 and blank display.
- R2: The rate field selects the scan length: 00 gives 8 rows, 01 gives 16, 10 gives 24 and 11 gives 32; a step taken on the last row of the selected length returns the row index to 0.
- R3: A step enable without sync advances the row index by exactly one; with neither step nor sync the row index holds.
- R4: Sync forces the row index to 0 at the next edge, whatever the step enable and the current row.
- R5: Row r reads bank (top bank + r/8) mod 4, the top bank being field values 0 to 3.
- R6: Row r takes bit (r mod 8) of each column byte, bit 0 being the top dot of the byte; column output c comes from column byte c, held in bits 8c+7 to 8c of the memory data.
- R7: Status code 00 (blank) drives every column output to 0 regardless of memory content.
- R8: Status code 01 (all on) drives every column output to 1 regardless of memory content.
- R9: Status code 10 (normal) passes the selected memory bits unchanged.
- R10: Status code 11 (inverse) drives the complement of the selected memory bits.
- R11: Rate, top bank and status are captured only in a cycle with the configuration write strobe high and govern the scan from the following edge on; changes on those inputs without the strobe have no effect.
- R12: If the scan length is shortened below the current row, the next step returns the row index to 0.
- R13: The row index and the column vector change together at the same clock edge, the column vector always belonging to the row index shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stepEn | input | 1 | External row step enable |
| syncIn | input | 1 | Row alignment pulse, returns the scan to row 0 |
| cfgWr | input | 1 | Configuration capture strobe |
| cfgRate | input | 2 | Scan length code |
| cfgTopBank | input | 2 | Bank shown at the top of the display |
| cfgStatus | input | 2 | Display status code |
| rdBank | output | 2 | Bank index presented to the display memory |
| ramData | input | 320 | Column bytes of the addressed bank, byte c in bits 8c+7..8c |
| rowIdx | output | 5 | Row currently driven |
| colOut | output | 40 | Column dot values of the current row |

## Verification
Sync and the end-of-scan wrap can both want to move the row counter in the same cycle, as can a configuration write and a row step. The bench drives sync together with a step on the last row of each rate, and issues configuration writes in the same cycle as steps, including ones that shorten the scan below the current row. A bench model that applies the old configuration to the step and the new one only from the next edge decides the expected row and column vector in every cycle.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  localparam int ROWS_PER_BANK = 8;
  localparam int NUM_BANKS     = 4;
  localparam int MAX_ROWS      = ROWS_PER_BANK * NUM_BANKS;
  localparam int ROW_W         = $clog2(MAX_ROWS);
  localparam int BIT_W         = $clog2(ROWS_PER_BANK);
  localparam int BANK_W        = $clog2(NUM_BANKS);

  typedef enum logic [1:0] {
    ST_BLANK  = 2'b00,
    ST_ALLON  = 2'b01,
    ST_NORMAL = 2'b10,
    ST_INVERT = 2'b11
  } dispStatus_e;

  typedef enum logic [1:0] {
    RATE_8  = 2'b00,
    RATE_16 = 2'b01,
    RATE_24 = 2'b10,
    RATE_32 = 2'b11
  } scanRate_e;

  typedef struct packed {
    logic [BIT_W-1:0] bitSel;
    dispStatus_e      status;
  } scanStrobe_t;
endpackage

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl
  import lcd_scan_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              stepEn,
  input  logic              syncIn,
  input  logic              cfgWr,
  input  logic [1:0]        cfgRate,
  input  logic [BANK_W-1:0] cfgTopBank,
  input  logic [1:0]        cfgStatus,
  output logic [BANK_W-1:0] rdBank,
  output logic [ROW_W-1:0]  rowIdx,
  output scanStrobe_t       strobe
);
  scanRate_e         rateReg;
  logic [BANK_W-1:0] topBankReg;
  dispStatus_e       statusReg;
  logic [ROW_W-1:0]  lastRow;
  logic [ROW_W-1:0]  nextRow;
  logic              atEnd;

  // Configuration capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rateReg    <= RATE_32;
      topBankReg <= '0;
      statusReg  <= ST_BLANK;
    end else if (cfgWr) begin
      rateReg    <= scanRate_e'(cfgRate);
      topBankReg <= cfgTopBank;
      statusReg  <= dispStatus_e'(cfgStatus);
    end
  end

  // Last row of the selected scan length: rate*8 + 7
  always_comb begin
    lastRow = {rateReg, {BIT_W{1'b1}}};
    atEnd   = (rowIdx >= lastRow);
  end

  // Next-row selection: sync has priority over stepping
  always_comb begin
    if (syncIn)
      nextRow = '0;
    else if (stepEn)
      nextRow = atEnd ? '0 : rowIdx + ROW_W'(1);
    else
      nextRow = rowIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rowIdx <= '0;
    else       rowIdx <= nextRow;
  end

  // Memory bank for the row about to be shown
  always_comb begin
    rdBank        = topBankReg + nextRow[ROW_W-1:BIT_W];
    strobe.bitSel = nextRow[BIT_W-1:0];
    strobe.status = statusReg;
  end

  AST_SYNC_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    syncIn |=> (rowIdx == '0)); // R4
  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && !syncIn && (rowIdx < lastRow)) |=> (rowIdx == $past(rowIdx) + ROW_W'(1))); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!stepEn && !syncIn) |=> $stable(rowIdx)); // R3
  AST_END_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && (rowIdx >= lastRow)) |=> (rowIdx == '0)); // R2
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWr |=> ($stable(rateReg) && $stable(topBankReg) && $stable(statusReg))); // R11
endmodule

// File: rtl/lcd_col_datapath.sv
module lcd_col_datapath
  import lcd_scan_pkg::*;
#(
  parameter int NUM_COLS = 40
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  scanStrobe_t                     strobe,
  input  logic [NUM_COLS*ROWS_PER_BANK-1:0] ramData,
  output logic [NUM_COLS-1:0]             colOut
);
  logic [NUM_COLS-1:0] rawBits;
  logic [NUM_COLS-1:0] shaped;

  // Pick the row bit from every column byte
  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    logic [ROWS_PER_BANK-1:0] colByte;
    assign colByte    = ramData[c*ROWS_PER_BANK +: ROWS_PER_BANK];
    assign rawBits[c] = colByte[strobe.bitSel];
  end

  always_comb begin
    unique case (strobe.status)
      ST_BLANK:  shaped = '0;
      ST_ALLON:  shaped = '1;
      ST_NORMAL: shaped = rawBits;
      ST_INVERT: shaped = ~rawBits;
      default:   shaped = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) colOut <= '0;
    else       colOut <= shaped;
  end

  AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.status == ST_BLANK) |=> (colOut == '0)); // R7
  AST_ALLON_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.status == ST_ALLON) |=> (colOut == '1)); // R8
endmodule

// File: rtl/lcd_row_scan.sv
module lcd_row_scan
  import lcd_scan_pkg::*;
#(
  parameter int NUM_COLS = 40
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                stepEn,
  input  logic                                syncIn,
  input  logic                                cfgWr,
  input  logic [1:0]                          cfgRate,
  input  logic [1:0]                          cfgTopBank,
  input  logic [1:0]                          cfgStatus,
  output logic [1:0]                          rdBank,
  input  logic [NUM_COLS*ROWS_PER_BANK-1:0]   ramData,
  output logic [4:0]                          rowIdx,
  output logic [NUM_COLS-1:0]                 colOut
);
  scanStrobe_t scanStb;

  lcd_scan_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .stepEn     (stepEn),
    .syncIn     (syncIn),
    .cfgWr      (cfgWr),
    .cfgRate    (cfgRate),
    .cfgTopBank (cfgTopBank),
    .cfgStatus  (cfgStatus),
    .rdBank     (rdBank),
    .rowIdx     (rowIdx),
    .strobe     (scanStb)
  );

  lcd_col_datapath #(.NUM_COLS(NUM_COLS)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (scanStb),
    .ramData (ramData),
    .colOut  (colOut)
  );

  AST_RESET_BLANK: assert property (@(posedge clk)
    !rstN |=> (rowIdx == '0 && colOut == '0)); // R1
endmodule

// File: tb/lcd_row_scan_tb_top.sv
`timescale 1ns/1ps
module lcd_row_scan_tb_top;
  localparam int NC = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stepEn = 1'b0, syncIn = 1'b0, cfgWr = 1'b0;
  logic [1:0] cfgRate = 2'b00, cfgTopBank = 2'b00, cfgStatus = 2'b00;
  logic [1:0] rdBank;
  logic [NC*8-1:0] ramData;
  logic [4:0] rowIdx;
  logic [NC-1:0] colOut;

  logic [7:0] ram [4][NC];

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic [4:0] mRow;
  logic [1:0] mRate, mBank, mStat;

  always #5 clk = ~clk;

  always_comb begin
    for (int c = 0; c < NC; c++) ramData[c*8 +: 8] = ram[rdBank][c];
  end

  lcd_row_scan dut_i (
    .clk(clk), .rstN(rstN), .stepEn(stepEn), .syncIn(syncIn), .cfgWr(cfgWr),
    .cfgRate(cfgRate), .cfgTopBank(cfgTopBank), .cfgStatus(cfgStatus),
    .rdBank(rdBank), .ramData(ramData), .rowIdx(rowIdx), .colOut(colOut)
  );

  function automatic logic [NC-1:0] expCol(logic [4:0] r, logic [1:0] tb, logic [1:0] st);
    logic [1:0] bk;
    logic [NC-1:0] v;
    bk = tb + r[4:3];
    for (int c = 0; c < NC; c++) v[c] = ram[bk][c][r[2:0]];
    case (st)
      2'b00: return '0;
      2'b01: return '1;
      2'b10: return v;
      default: return ~v;
    endcase
  endfunction

  task automatic chk(bit ok, string req, logic [NC-1:0] act, logic [NC-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fillRam();
    for (int b = 0; b < 4; b++)
      for (int c = 0; c < NC; c++) ram[b][c] = 8'($urandom);
  endtask

  task automatic cyc(bit st, bit sy, bit wr, logic [1:0] r, logic [1:0] b,
                     logic [1:0] s, string req);
    logic [4:0] nRow;
    logic [NC-1:0] eCol;
    @(negedge clk);
    stepEn = st; syncIn = sy; cfgWr = wr;
    cfgRate = r; cfgTopBank = b; cfgStatus = s;
    if (sy) nRow = '0;
    else if (st) nRow = (mRow >= {mRate, 3'b111}) ? 5'd0 : mRow + 5'd1;
    else nRow = mRow;
    eCol = expCol(nRow, mBank, mStat);
    @(posedge clk); #1;
    chk(rowIdx == nRow, req, NC'(rowIdx), NC'(nRow));
    chk(colOut == eCol, req, colOut, eCol);
    mRow = nRow;
    if (wr) begin mRate = r; mBank = b; mStat = s; end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    fillRam();
    mRow = 0; mRate = 2'b11; mBank = 0; mStat = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    // R1: reset state
    chk(rowIdx == 0, "R1", NC'(rowIdx), '0);
    chk(colOut == '0, "R1", colOut, '0);
    // R1: default 32-row scan, blank while stepping
    for (int i = 0; i < 33; i++) cyc(1, 0, 0, 2'b01, 2'b10, 2'b10, "R1");
    // R11: inputs changed without strobe are ignored (still blank, 32 rows)
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, 2'b00, 2'b11, 2'b11, "R11");
    // R11/R9: capture normal video, 32 rows, bank 0
    cyc(0, 1, 1, 2'b11, 2'b00, 2'b10, "R11");
    // R5 R6 R9 R13: walk a full frame in normal video
    for (int i = 0; i < 32; i++) cyc(1, 0, 0, 2'b00, 2'b00, 2'b00, "R9");
    // R3: idle holds
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 2'b00, 2'b00, 2'b00, "R3");
    // R5: rotated top bank
    cyc(1, 0, 1, 2'b11, 2'b10, 2'b10, "R5");
    for (int i = 0; i < 34; i++) cyc(1, 0, 0, 2'b00, 2'b00, 2'b00, "R5");
    // R6: change memory, row bit selection re-evaluated
    fillRam();
    for (int i = 0; i < 9; i++) cyc(1, 0, 0, 2'b00, 2'b00, 2'b00, "R6");
    // R10: inverse
    cyc(0, 0, 1, 2'b11, 2'b01, 2'b11, "R10");
    for (int i = 0; i < 10; i++) cyc(1, 0, 0, 2'b00, 2'b00, 2'b00, "R10");
    // R8: all on
    cyc(1, 0, 1, 2'b11, 2'b01, 2'b01, "R8");
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, 2'b00, 2'b00, 2'b00, "R8");
    // R7: blank
    cyc(1, 0, 1, 2'b11, 2'b01, 2'b00, "R7");
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, 2'b00, 2'b00, 2'b00, "R7");
    // R2: each rate wraps after its last row; sync with step on last row (R4)
    for (int rt = 0; rt < 4; rt++) begin
      cyc(0, 1, 1, 2'(rt), 2'b00, 2'b10, "R4");
      for (int i = 0; i < (rt + 1) * 8 + 2; i++) cyc(1, 0, 0, 2'(rt), 2'b00, 2'b10, "R2");
      cyc(0, 1, 0, 2'(rt), 2'b00, 2'b10, "R4");
      for (int i = 0; i < (rt + 1) * 8 - 1; i++) cyc(1, 0, 0, 2'(rt), 2'b00, 2'b10, "R2");
      cyc(1, 1, 0, 2'(rt), 2'b00, 2'b10, "R4");
    end
    // R12: shorten the scan below the current row
    cyc(0, 1, 1, 2'b11, 2'b00, 2'b10, "R12");
    for (int i = 0; i < 20; i++) cyc(1, 0, 0, 2'b00, 2'b00, 2'b00, "R12");
    cyc(0, 0, 1, 2'b00, 2'b11, 2'b10, "R12");
    cyc(1, 0, 0, 2'b00, 2'b00, 2'b00, "R12");
    chk(rowIdx == 0, "R12", NC'(rowIdx), '0);
    // R3 R4 R13: constrained random mix
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 64) == 0) fillRam();
      cyc(($urandom % 4) != 0, ($urandom % 40) == 0, ($urandom % 25) == 0,
          2'($urandom), 2'($urandom), 2'($urandom), "R13");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule